// File: doc/BRIEF.md
# VFD Multiplexed Grid Scanner

This block refreshes a multiplexed vacuum fluorescent display from a small on-chip pattern store of twelve 24-bit words. It steps through the digit positions one slot at a time. In each slot it drives exactly one grid, and it drives the segment lines with the pattern stored for that digit. A scan tick enable supplies the time base. Every slot lasts sixteen ticks. The lit part of the slot sits at the front, and its length comes from an eight-step brightness level. The rest of the slot is dark, which keeps a digit from ghosting onto its neighbour.

The output side has sixteen fixed segment lines, four fixed grid lines and eight shared lines. The programmed digit count, from 4 to 12, decides which shared lines act as extra segments and which act as extra grids. With more digits there are fewer segments, so 12 digits gives 16 segments and 4 digits gives 24 segments. A one-clock pulse marks the end of every full display cycle, so that key-capture logic can sample at that moment. A display-off control darkens every line while the scan keeps running.

Top module: `vfd_grid_scanner`

## Requirements
- R1: While reset is asserted, and after its release until the display is switched on, every segment, grid and shared line and the cycle-end pulse is 0. Every pattern word resets to 0.
- R2: A write with `wr_en` high and `wr_addr` = n stores `wr_data` as the pattern of digit n+1, and the write is visible from the next clock. Writes to addresses of 12 or more are ignored. During a lit tick of digit n+1, pattern bit i (0..15) drives `seg_fix_o[i]` (segment i+1), and bit 16+k drives `shared_o[k]` when that line acts as a segment.
- R3: During a lit tick, exactly one grid line is high: the grid of the current digit. Digit index i (0..3) maps to `grid_fix_o[i]`, and digit index i (4..11) maps to `shared_o[11-i]`. Digits run 1, 2, ... G and then wrap to 1.
- R4: With G digits selected, shared line k (0..7) acts as segment 17+k when k < 12-G, and as grid 12-k otherwise.
- R5: A slot lasts 16 ticks. With brightness level d (0..7), ticks 0 to 2d of the slot are lit. On every other tick of the slot all lines are 0, and tick 15 is always dark.
- R6: The brightness level is sampled only at the start of a slot. A change in the middle of a slot leaves the rest of that slot unchanged.
- R7: `cycle_end_o` is high for exactly one clock, right after the tick that ends the last digit's slot. From that point the scan is at digit 1, tick 0. It occurs once every 16·G ticks.
- R8: The digit count after reset is 12. A new `digit_mode` takes effect only at the wrap to digit 1. A change in the middle of a cycle leaves that cycle's length unchanged.
- R9: A `digit_mode` below 4 selects 4 digits, and a value above 12 selects 12 digits.
- R10: `disp_on` is registered. From the clock after it goes low, every line is 0, while the tick, digit and cycle-end timing continue unchanged.
- R11: While `tick_en` is low, the tick and digit position hold, the outputs stay constant and no cycle-end pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Scan tick enable, one tick per high cycle |
| disp_on | input | 1 | Display enable, 0 darkens all lines |
| dim_level | input | 3 | Brightness level 0..7 |
| digit_mode | input | 4 | Requested digit count, clamped to 4..12 |
| wr_en | input | 1 | Pattern write strobe |
| wr_addr | input | 4 | Pattern word address (digit index) |
| wr_data | input | 24 | Pattern word, bit i is segment i+1 |
| seg_fix_o | output | 16 | Segments 1..16 |
| grid_fix_o | output | 4 | Grids 1..4 |
| shared_o | output | 8 | Line k: segment 17+k or grid 12-k |
| cycle_end_o | output | 1 | One-clock end-of-cycle pulse |

## Verification
Every output line is decoded from flops without any input in the path. A tick enable sampled at one rising edge therefore changes the pins right after that same edge. A pattern write and a change of `disp_on` appear one edge after they are sampled. Brightness and digit count wait for the edge that ends a slot or a cycle, and `cycle_end_o` is high during the clock that follows the final tick. The bench drives and samples on falling edges. It synchronises on the cycle-end pulse and then counts ticks from that pulse, so every expected value is compared at the tick and digit position it belongs to.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

  // Role taken by one shared output line in the current mode.
  typedef enum logic {
    LINE_SEG  = 1'b0,
    LINE_GRID = 1'b1
  } line_role_e;

  // Lit ticks per slot for a brightness level.
  function automatic int unsigned lit_ticks(input int unsigned level);
    return 2 * level + 1;
  endfunction

  // Clamp a requested digit count into the supported range.
  function automatic int unsigned fit_digits(input int unsigned req,
                                             input int unsigned lo,
                                             input int unsigned hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

endpackage

// File: rtl/vfd_slot_timer.sv
module vfd_slot_timer
  import vfd_scan_pkg::*;
#(
  parameter  int SLOT_TICKS = 16,
  parameter  int DIM_W      = 3,
  localparam int TICK_W     = $clog2(SLOT_TICKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [DIM_W-1:0]  dim_level,
  output logic [TICK_W-1:0] tick_q,
  output logic              slot_wrap,
  output logic              lit
);

  logic [DIM_W-1:0]  dim_q, dim_d;
  logic [TICK_W-1:0] tick_d;
  logic              slot_last;

  assign slot_last = (tick_q == TICK_W'(SLOT_TICKS - 1));
  assign slot_wrap = tick_en && slot_last;

  always_comb begin
    tick_d = tick_q;
    dim_d  = dim_q;
    if (tick_en) begin
      if (slot_last) begin
        tick_d = '0;
        dim_d  = dim_level;
      end else begin
        tick_d = tick_q + TICK_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      dim_q  <= '0;
    end else begin
      tick_q <= tick_d;
      dim_q  <= dim_d;
    end
  end

  assign lit = (32'(tick_q) < lit_ticks(32'(dim_q)));

endmodule

// File: rtl/vfd_digit_seq.sv
module vfd_digit_seq
  import vfd_scan_pkg::*;
#(
  parameter  int NUM_WORDS = 12,
  parameter  int MIN_DIG   = 4,
  localparam int DIG_W     = $clog2(NUM_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_wrap,
  input  logic [DIG_W-1:0] mode_req,
  output logic [DIG_W-1:0] digit_q,
  output logic [DIG_W-1:0] ndig_q,
  output logic             cycle_end
);

  logic [DIG_W-1:0] digit_d, ndig_d, req_fit;
  logic             cyc_d, last_digit;

  assign req_fit    = DIG_W'(fit_digits(32'(mode_req), MIN_DIG, NUM_WORDS));
  assign last_digit = (digit_q == ndig_q - DIG_W'(1));

  always_comb begin
    digit_d = digit_q;
    ndig_d  = ndig_q;
    cyc_d   = 1'b0;
    if (slot_wrap) begin
      if (last_digit) begin
        digit_d = '0;
        ndig_d  = req_fit;
        cyc_d   = 1'b1;
      end else begin
        digit_d = digit_q + DIG_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      digit_q   <= '0;
      ndig_q    <= DIG_W'(NUM_WORDS);
      cycle_end <= 1'b0;
    end else begin
      digit_q   <= digit_d;
      ndig_q    <= ndig_d;
      cycle_end <= cyc_d;
    end
  end

endmodule

// File: rtl/vfd_disp_mem.sv
module vfd_disp_mem #(
  parameter  int NUM_WORDS = 12,
  parameter  int SEG_W     = 24,
  localparam int ADDR_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SEG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [SEG_W-1:0]  rd_data
);

  logic [SEG_W-1:0] words [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words[w] <= '0;
      end else if (hit) begin
        words[w] <= wr_data;
      end
    end
  end

  assign rd_data = words[rd_addr];

endmodule

// File: rtl/vfd_pin_steer.sv
module vfd_pin_steer
  import vfd_scan_pkg::*;
#(
  parameter  int NUM_WORDS = 12,
  parameter  int SEG_W     = 24,
  parameter  int FIX_SEG   = 16,
  parameter  int FIX_GRID  = 4,
  localparam int SHARED    = SEG_W - FIX_SEG,
  localparam int DIG_W     = $clog2(NUM_WORDS + 1)
) (
  input  logic                active,
  input  logic [DIG_W-1:0]    digit,
  input  logic [DIG_W-1:0]    ndig,
  input  logic [SEG_W-1:0]    word,
  output logic [FIX_SEG-1:0]  seg_fix,
  output logic [FIX_GRID-1:0] grid_fix,
  output logic [SHARED-1:0]   shared
);

  assign seg_fix = active ? word[FIX_SEG-1:0] : '0;

  for (genvar i = 0; i < FIX_GRID; i++) begin : g_fix_grid
    assign grid_fix[i] = active && (digit == DIG_W'(i));
  end

  // Shared line k doubles as segment FIX_SEG+k+1 or grid NUM_WORDS-k.
  for (genvar k = 0; k < SHARED; k++) begin : g_shared
    localparam int GIDX = NUM_WORDS - 1 - k;
    line_role_e role;
    assign role      = (DIG_W'(GIDX) < ndig) ? LINE_GRID : LINE_SEG;
    assign shared[k] = (role == LINE_GRID) ? (active && (digit == DIG_W'(GIDX)))
                                           : (active && word[FIX_SEG + k]);
  end

endmodule

// File: rtl/vfd_grid_scanner.sv
module vfd_grid_scanner
  import vfd_scan_pkg::*;
#(
  parameter  int NUM_WORDS  = 12,
  parameter  int SEG_W      = 24,
  parameter  int FIX_SEG    = 16,
  parameter  int FIX_GRID   = 4,
  parameter  int SLOT_TICKS = 16,
  parameter  int DIM_W      = 3,
  localparam int SHARED     = SEG_W - FIX_SEG,
  localparam int DIG_W      = $clog2(NUM_WORDS + 1),
  localparam int ADDR_W     = $clog2(NUM_WORDS),
  localparam int TICK_W     = $clog2(SLOT_TICKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                disp_on,
  input  logic [DIM_W-1:0]    dim_level,
  input  logic [DIG_W-1:0]    digit_mode,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [SEG_W-1:0]    wr_data,
  output logic [FIX_SEG-1:0]  seg_fix_o,
  output logic [FIX_GRID-1:0] grid_fix_o,
  output logic [SHARED-1:0]   shared_o,
  output logic                cycle_end_o
);

  logic [TICK_W-1:0] tick_q;
  logic [DIG_W-1:0]  digit_q, ndig_q;
  logic [SEG_W-1:0]  cur_word;
  logic              slot_wrap, lit, on_q, on_d, active;

  assign on_d = disp_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) on_q <= 1'b0;
    else        on_q <= on_d;
  end

  vfd_slot_timer #(
    .SLOT_TICKS (SLOT_TICKS),
    .DIM_W      (DIM_W)
  ) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .dim_level (dim_level),
    .tick_q    (tick_q),
    .slot_wrap (slot_wrap),
    .lit       (lit)
  );

  vfd_digit_seq #(
    .NUM_WORDS (NUM_WORDS),
    .MIN_DIG   (FIX_GRID)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_wrap (slot_wrap),
    .mode_req  (digit_mode),
    .digit_q   (digit_q),
    .ndig_q    (ndig_q),
    .cycle_end (cycle_end_o)
  );

  vfd_disp_mem #(
    .NUM_WORDS (NUM_WORDS),
    .SEG_W     (SEG_W)
  ) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (digit_q[ADDR_W-1:0]),
    .rd_data (cur_word)
  );

  assign active = lit && on_q;

  vfd_pin_steer #(
    .NUM_WORDS (NUM_WORDS),
    .SEG_W     (SEG_W),
    .FIX_SEG   (FIX_SEG),
    .FIX_GRID  (FIX_GRID)
  ) u_steer (
    .active   (active),
    .digit    (digit_q),
    .ndig     (ndig_q),
    .word     (cur_word),
    .seg_fix  (seg_fix_o),
    .grid_fix (grid_fix_o),
    .shared   (shared_o)
  );

endmodule

// File: rtl/vfd_scan_chk.sv
module vfd_scan_chk #(
  parameter  int NUM_WORDS  = 12,
  parameter  int SEG_W      = 24,
  parameter  int FIX_SEG    = 16,
  parameter  int FIX_GRID   = 4,
  parameter  int SLOT_TICKS = 16,
  localparam int SHARED     = SEG_W - FIX_SEG,
  localparam int DIG_W      = $clog2(NUM_WORDS + 1),
  localparam int TICK_W     = $clog2(SLOT_TICKS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick_en,
  input logic                disp_on,
  input logic [TICK_W-1:0]   tick_q,
  input logic [DIG_W-1:0]    digit_q,
  input logic [DIG_W-1:0]    ndig_q,
  input logic [FIX_SEG-1:0]  seg_fix_o,
  input logic [FIX_GRID-1:0] grid_fix_o,
  input logic [SHARED-1:0]   shared_o,
  input logic                cycle_end_o
);

  logic any_out;
  assign any_out = (|seg_fix_o) || (|grid_fix_o) || (|shared_o);

  // R3
  one_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grid_fix_o));

  // R4
  all_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ndig_q == DIG_W'(NUM_WORDS)) |-> $onehot0({shared_o, grid_fix_o}));

  // R5
  last_tick_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q == TICK_W'(SLOT_TICKS - 1)) |-> !any_out);

  // R7
  cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end_o |=> !cycle_end_o);

  // R7
  cycle_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end_o |-> (digit_q == '0) && (tick_q == '0));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ndig_q) |-> (digit_q == '0) && (tick_q == '0));

  // R9
  mode_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ndig_q >= DIG_W'(FIX_GRID)) && (ndig_q <= DIG_W'(NUM_WORDS)));

  // R10
  dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(disp_on) |-> !any_out);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(tick_q) && $stable(digit_q));

endmodule

bind vfd_grid_scanner vfd_scan_chk #(
  .NUM_WORDS  (NUM_WORDS),
  .SEG_W      (SEG_W),
  .FIX_SEG    (FIX_SEG),
  .FIX_GRID   (FIX_GRID),
  .SLOT_TICKS (SLOT_TICKS)
) u_scan_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .disp_on     (disp_on),
  .tick_q      (tick_q),
  .digit_q     (digit_q),
  .ndig_q      (ndig_q),
  .seg_fix_o   (seg_fix_o),
  .grid_fix_o  (grid_fix_o),
  .shared_o    (shared_o),
  .cycle_end_o (cycle_end_o)
);

// File: tb/test_vfd_grid_scanner.sv
module test_vfd_grid_scanner;

  logic        clk = 1'b0;
  logic        rst_n, tick_en, disp_on, wr_en;
  logic [2:0]  dim_level;
  logic [3:0]  digit_mode, wr_addr;
  logic [23:0] wr_data;
  logic [15:0] seg_fix_o;
  logic [3:0]  grid_fix_o;
  logic [7:0]  shared_o;
  logic        cycle_end_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [23:0] sh_mem [12];

  always #4 clk = ~clk;

  vfd_grid_scanner i_vfd_grid_scanner (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .disp_on(disp_on),
    .dim_level(dim_level), .digit_mode(digit_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .seg_fix_o(seg_fix_o),
    .grid_fix_o(grid_fix_o), .shared_o(shared_o), .cycle_end_o(cycle_end_o)
  );

  typedef struct packed {
    logic [3:0] mode;
    logic [2:0] dim;
    logic [7:0] cyc_ticks;
  } row_t;

  localparam int ROWS = 6;
  localparam row_t TABLE [ROWS] = '{
    '{4'd12, 3'd0, 8'd192},
    '{4'd4,  3'd7, 8'd64},
    '{4'd8,  3'd3, 8'd128},
    '{4'd2,  3'd5, 8'd64},   // R9 low clamp
    '{4'd15, 3'd1, 8'd192},  // R9 high clamp
    '{4'd7,  3'd6, 8'd112}
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [23:0] pat(input int w, input int seed);
    return 24'((w + 1) * 24'h0B3A57) ^ 24'(seed * 24'h5D1EC3) ^ 24'hA50F3C;
  endfunction

  // Expected {shared, grid_fix, seg_fix} from the requirements.
  function automatic logic [27:0] expect_pins(input int g, input int d, input int dig,
                                              input int tk, input bit on);
    logic [15:0] sf = '0;
    logic [3:0]  gf = '0;
    logic [7:0]  sh = '0;
    logic [23:0] w  = sh_mem[dig];
    if (on && tk < 2 * d + 1) begin
      sf = w[15:0];
      for (int i = 0; i < 4; i++) gf[i] = (dig == i);
      for (int k = 0; k < 8; k++) sh[k] = (k < 12 - g) ? w[16 + k] : (dig == 11 - k);
    end
    return {sh, gf, sf};
  endfunction

  function automatic logic [27:0] pins();
    return {shared_o, grid_fix_o, seg_fix_o};
  endfunction

  task automatic write_word(input int a, input logic [23:0] v);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 12) sh_mem[a] = v;
  endtask

  task automatic load_mem(input int seed);
    for (int a = 0; a < 12; a++) write_word(a, pat(a, seed));
    write_word(12, 24'hFFFFFF);  // R2 out-of-range write ignored
    write_word(15, 24'hFFFFFF);
  endtask

  task automatic wait_cycle_end();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cycle_end_o && n < 400);
    chk("R7 sync pulse", 64'(cycle_end_o), 64'd1);
  endtask

  // Starts at the sample where the scan sits at digit 1 tick 0.
  task automatic run_cycle(input int g, input int d, input bit on, input bit start_pulse,
                           input string tag);
    for (int t = 0; t < 16 * g; t++) begin
      chk({"R2 R3 R4 R5 ", tag}, 64'(pins()), 64'(expect_pins(g, d, t / 16, t % 16, on)));
      chk({"R7 ", tag}, 64'(cycle_end_o), 64'((t == 0) && start_pulse));
      @(negedge clk);
    end
    chk({"R7 cycle length ", tag}, 64'(cycle_end_o), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; disp_on = 1'b0; wr_en = 1'b0;
    dim_level = '0; digit_mode = 4'd12; wr_addr = '0; wr_data = '0;
    for (int a = 0; a < 12; a++) sh_mem[a] = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 64'({pins(), cycle_end_o}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 64'({pins(), cycle_end_o}), 64'd0);

    load_mem(0);
    chk("R1 dark before enable", 64'(pins()), 64'd0);

    // R11: no ticks; display on, scan parked at digit 1 tick 0, level 0.
    disp_on = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      chk("R11 hold", 64'(pins()), 64'(expect_pins(12, 0, 0, 0, 1)));
      chk("R11 no pulse", 64'(cycle_end_o), 64'd0);
      @(negedge clk);
    end

    // R8: reset count is 12; mode 5 requested mid-run waits for the wrap.
    digit_mode = 4'd5;
    tick_en = 1'b1;
    run_cycle(12, 0, 1, 0, "R8 reset mode");
    run_cycle(5, 0, 1, 1, "R8 new mode");

    // Table of modes and levels.
    for (int r = 0; r < ROWS; r++) begin
      load_mem(r + 1);
      digit_mode = TABLE[r].mode;
      dim_level  = TABLE[r].dim;
      wait_cycle_end();
      run_cycle(int'(TABLE[r].cyc_ticks) / 16, int'(TABLE[r].dim), 1, 1, "R9 table");
    end

    // R6: level change in mid slot.
    digit_mode = 4'd4;
    dim_level  = 3'd0;
    wait_cycle_end();
    wait_cycle_end();
    for (int t = 0; t < 32; t++) begin
      if (t == 2) dim_level = 3'd7;
      chk("R6 mid-slot level", 64'(pins()), 64'(expect_pins(4, (t < 16) ? 0 : 7, t / 16, t % 16, 1)));
      @(negedge clk);
    end

    // R10: display off keeps timing.
    disp_on = 1'b0;
    wait_cycle_end();
    run_cycle(4, 7, 0, 1, "R10 display off");
    disp_on = 1'b1;
    wait_cycle_end();
    run_cycle(4, 7, 1, 1, "R10 display back on");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule